// File: doc/BRIEF.md
# Receiver Error Flag and Interrupt Logic

This block sits beside the data path of a serial digital-audio receiver. Four per-sample error conditions come in on `err_cond`: loss of lock, coding violation, parity error and validity flag. A four-bit enable register selects which of them count. The block gives three views of the enabled conditions. A frame-aligned error pin marks each erroneous sample. A sticky status bit records the first error until software reads the status. An active-low interrupt line combines the sticky request with a fixed-shape pulse that follows every internal buffer-RAM write.

Everything runs on the bit clock, which runs at 64 times the sample rate. The frame-sync input is sampled on that clock. Its rising edge marks the start of a new sample. Errors seen during one frame collect in a pending register. At the next frame start they move to the pin, which then holds that value for a whole frame. Every write strobe from the buffer logic starts a timer. The timer pulls the interrupt line low for a fixed number of bit clocks after a fixed delay, so a host can work out which buffer byte was just updated.

Top module: `audrx_errirq`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are `err_pin`=0, `err_sticky`=0 and `irq_n`=1. The enable register becomes 4'b1111, so all four conditions count.
- R2: `err_cond` bit 0 is loss of lock, bit 1 is coding violation, bit 2 is parity error and bit 3 is validity. A condition counts only when the bit in the same position of the enable register is 1. A condition that does not count changes neither `err_pin` nor `err_sticky`.
- R3: A cycle in which `mask_we` is high loads `mask_wdata` into the enable register at the end of that cycle. The errors of that same cycle are still qualified by the old enables.
- R4: A frame start is a cycle in which `fsync` is high and was low in the cycle before. `err_pin` changes only at the clock edge that ends a frame-start cycle.
- R5: At the edge ending a frame-start cycle, `err_pin` becomes 1 exactly when some enabled error was present in the previous frame. The previous frame runs from the preceding frame-start cycle up to the cycle before the current one, both ends included. The next frame's record starts with the current cycle.
- R6: Any cycle with an enabled error sets `err_sticky` at its closing edge. The bit then stays set until a cycle with `stat_rd` high clears it.
- R7: If `stat_rd` and an enabled error occur in the same cycle, `err_sticky` stays set.
- R8: When `ram_wr` is high at edge k and there is no later write, `irq_n` is low after edges k+5, k+6, k+7 and k+8 only. That is a 4-cycle pulse.
- R9: A write strobe during a pulse sequence restarts the timing from the new write. The earlier sequence is dropped.
- R10: `irq_n` is low whenever `err_sticky` is 1, in addition to the write pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, 64 times the sample rate |
| rst | input | 1 | Synchronous reset, active high |
| fsync | input | 1 | Frame sync; a rising edge starts a sample |
| err_cond | input | 4 | Error conditions: [0] lock, [1] code, [2] parity, [3] validity |
| mask_we | input | 1 | Write strobe for the enable register |
| mask_wdata | input | 4 | New enable bits, 1 = condition counts |
| stat_rd | input | 1 | Status read strobe, clears the sticky bit |
| ram_wr | input | 1 | Internal buffer-RAM write strobe |
| err_pin | output | 1 | Per-sample error flag, aligned to frames |
| err_sticky | output | 1 | Sticky error status bit |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A wrong pending bit or a mistimed frame-start detector shows on `err_pin` at the next frame start. That is at most one frame, 64 bit clocks in normal use, after the cause. A wrong enable bit or a wrong sticky bit shows on `err_sticky` and `irq_n` one edge after the first error it affects. An off-by-one in the write timer moves the front or the back of the `irq_n` pulse by one edge within nine cycles of the write. The random run uses frame lengths shorter than 64 so that these effects show up often.

// File: rtl/aerr_pkg.sv
package aerr_pkg;

    localparam int NCOND = 4;

    typedef enum logic [1:0] {
        COND_LOCK   = 2'd0,
        COND_CODE   = 2'd1,
        COND_PARITY = 2'd2,
        COND_VALID  = 2'd3
    } cond_idx_e;

    typedef struct packed {
        logic fs_prev;
        logic pend;
        logic pin;
    } frame_st_t;

    typedef struct packed {
        logic flag;
    } sticky_st_t;

endpackage

// File: rtl/aerr_qual.sv
module aerr_qual
    import aerr_pkg::*;
#(
    parameter int N = NCOND
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] cond,
    input  logic         we,
    input  logic [N-1:0] wdata,
    output logic         any_err
);
    typedef struct packed {
        logic [N-1:0] en;
    } qual_st_t;

    qual_st_t     st_q, st_d;
    logic [N-1:0] hit;

    generate
        for (genvar i = 0; i < N; i++) begin : g_hit
            assign hit[i] = cond[i] & st_q.en[i];
        end
    endgenerate

    assign any_err = |hit;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.en = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.en <= '1;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/aerr_frame.sv
module aerr_frame
    import aerr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fsync,
    input  logic any_err,
    output logic pin
);
    frame_st_t st_q, st_d;
    logic      fs_start;

    assign fs_start = fsync & ~st_q.fs_prev;
    assign pin      = st_q.pin;

    always_comb begin
        st_d         = st_q;
        st_d.fs_prev = fsync;
        if (fs_start) begin
            st_d.pin  = st_q.pend;
            st_d.pend = any_err;
        end else begin
            st_d.pend = st_q.pend | any_err;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/aerr_sticky.sv
module aerr_sticky
    import aerr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic any_err,
    input  logic rd,
    output logic flag
);
    sticky_st_t st_q, st_d;

    assign flag = st_q.flag;

    always_comb begin
        st_d = st_q;
        if (rd) begin
            st_d.flag = 1'b0;
        end
        if (any_err) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/aerr_wrtimer.sv
module aerr_wrtimer #(
    parameter int DELAY = 5,
    parameter int WIDTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic wr,
    output logic pulse_n
);
    localparam int LAST = DELAY + WIDTH;
    localparam int CW   = $clog2(LAST + 1);
    localparam logic [CW-1:0] C_ONE   = CW'(1);
    localparam logic [CW-1:0] C_FIRST = CW'(DELAY + 1);
    localparam logic [CW-1:0] C_LAST  = CW'(LAST);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_st_t;

    tmr_st_t st_q, st_d;

    assign pulse_n = ~((st_q.cnt >= C_FIRST) && (st_q.cnt <= C_LAST));

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.cnt = C_ONE;
        end else if (st_q.cnt == '0 || st_q.cnt == C_LAST) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + C_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/audrx_errirq.sv
module audrx_errirq
    import aerr_pkg::*;
#(
    parameter int N        = NCOND,
    parameter int WR_DELAY = 5,
    parameter int WR_WIDTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         fsync,
    input  logic [N-1:0] err_cond,
    input  logic         mask_we,
    input  logic [N-1:0] mask_wdata,
    input  logic         stat_rd,
    input  logic         ram_wr,
    output logic         err_pin,
    output logic         err_sticky,
    output logic         irq_n
);
    logic any_err;
    logic wr_pulse_n;

    aerr_qual #(.N(N)) u_qual (
        .clk     (clk),
        .rst     (rst),
        .cond    (err_cond),
        .we      (mask_we),
        .wdata   (mask_wdata),
        .any_err (any_err)
    );

    aerr_frame u_frame (
        .clk     (clk),
        .rst     (rst),
        .fsync   (fsync),
        .any_err (any_err),
        .pin     (err_pin)
    );

    aerr_sticky u_sticky (
        .clk     (clk),
        .rst     (rst),
        .any_err (any_err),
        .rd      (stat_rd),
        .flag    (err_sticky)
    );

    aerr_wrtimer #(.DELAY(WR_DELAY), .WIDTH(WR_WIDTH)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .wr      (ram_wr),
        .pulse_n (wr_pulse_n)
    );

    assign irq_n = wr_pulse_n & ~err_sticky;
endmodule

// File: rtl/audrx_errirq_chk.sv
module audrx_errirq_chk #(
    parameter int WR_DELAY = 5,
    parameter int WR_WIDTH = 4
) (
    input logic clk,
    input logic rst,
    input logic fsync,
    input logic any_err,
    input logic stat_rd,
    input logic ram_wr,
    input logic err_pin,
    input logic err_sticky,
    input logic irq_n
);
    localparam int HORIZON = WR_DELAY + WR_WIDTH + 2;

    logic fs_seen;
    int   since_wr;
    logic in_win;

    always_ff @(posedge clk) begin
        if (rst) begin
            fs_seen  <= 1'b0;
            since_wr <= HORIZON;
        end else begin
            fs_seen <= fsync;
            if (ram_wr) begin
                since_wr <= 0;
            end else if (since_wr < HORIZON) begin
                since_wr <= since_wr + 1;
            end
        end
    end

    assign in_win = (since_wr >= WR_DELAY) && (since_wr < WR_DELAY + WR_WIDTH);

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (!err_pin && !err_sticky && irq_n));

    p_pin_only_at_start_r4: assert property (@(posedge clk) disable iff (rst)
        !(fsync && !fs_seen) |=> $stable(err_pin));

    p_sticky_sets_r6: assert property (@(posedge clk) disable iff (rst)
        any_err |=> err_sticky);

    p_sticky_holds_r6: assert property (@(posedge clk) disable iff (rst)
        (err_sticky && !stat_rd) |=> err_sticky);

    p_irq_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        err_sticky |-> !irq_n);

    p_irq_cause_r8: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> (err_sticky || in_win));

    p_irq_window_r9: assert property (@(posedge clk) disable iff (rst)
        in_win |-> !irq_n);
endmodule

bind audrx_errirq audrx_errirq_chk #(.WR_DELAY(WR_DELAY), .WR_WIDTH(WR_WIDTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .fsync      (fsync),
    .any_err    (any_err),
    .stat_rd    (stat_rd),
    .ram_wr     (ram_wr),
    .err_pin    (err_pin),
    .err_sticky (err_sticky),
    .irq_n      (irq_n)
);

// File: tb/sim_audrx_errirq.sv
`timescale 1ns/1ps
module sim_audrx_errirq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fsync = 1'b0;
    logic [3:0] err_cond = '0;
    logic       mask_we = 1'b0;
    logic [3:0] mask_wdata = '0;
    logic       stat_rd = 1'b0;
    logic       ram_wr = 1'b0;
    logic       err_pin, err_sticky, irq_n;

    int total = 0;
    int bad = 0;
    bit checking = 0;
    string tag_pin = "R5";
    string tag_stk = "R6";
    string tag_irq = "R8";

    // bench model state
    logic [3:0] m_mask = 4'hF;
    logic       m_fsprev = 0, m_pend = 0, m_pin = 0, m_sticky = 0;
    int         m_since = 100;

    always #2.5 clk = ~clk;

    audrx_errirq u0 (
        .clk(clk), .rst(rst), .fsync(fsync), .err_cond(err_cond),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .stat_rd(stat_rd),
        .ram_wr(ram_wr), .err_pin(err_pin), .err_sticky(err_sticky), .irq_n(irq_n)
    );

    function automatic logic exp_irq();
        return !m_sticky && !(m_since >= 5 && m_since <= 8);
    endfunction

    task automatic chk(input string req, input string nm, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, nm, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        logic anyv, st;
        anyv = |(err_cond & m_mask);
        st   = fsync & ~m_fsprev;
        if (rst) begin
            m_mask = 4'hF; m_fsprev = 0; m_pend = 0; m_pin = 0; m_sticky = 0; m_since = 100;
        end else begin
            if (st) begin m_pin = m_pend; m_pend = anyv; end
            else m_pend = m_pend | anyv;
            m_sticky = (m_sticky & ~stat_rd) | anyv;
            if (ram_wr) m_since = 0; else if (m_since < 100) m_since++;
            if (mask_we) m_mask = mask_wdata;
            m_fsprev = fsync;
        end
    endtask

    // one cycle: check outputs after the previous edge, drive new inputs, advance model
    task automatic cyc(input logic r, input logic fs, input logic [3:0] c, input logic mw,
                       input logic [3:0] md, input logic rd, input logic wr);
        @(negedge clk);
        if (checking) begin
            chk(tag_pin, "err_pin", err_pin, m_pin);
            chk(tag_stk, "err_sticky", err_sticky, m_sticky);
            chk(tag_irq, "irq_n", irq_n, exp_irq());
        end
        rst = r; fsync = fs; err_cond = c; mask_we = mw; mask_wdata = md;
        stat_rd = rd; ram_wr = wr;
        model_edge();
    endtask

    task automatic idle(input int n, input logic fs);
        for (int i = 0; i < n; i++) cyc(0, fs, 4'h0, 0, 4'h0, 0, 0);
    endtask

    initial begin : watchdog
        #(5.0 * 150000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int phase, flen;
        process::self().srandom(32'd4711);
        cyc(1, 0, 0, 0, 0, 0, 0);
        cyc(1, 0, 4'hF, 0, 0, 1, 1);
        checking = 1;
        // R1: reset state
        tag_pin = "R1"; tag_stk = "R1"; tag_irq = "R1";
        cyc(0, 0, 0, 0, 0, 0, 0);

        // R2: each condition alone sets sticky with reset enables (all on)
        tag_stk = "R2"; tag_pin = "R2"; tag_irq = "R10";
        for (int b = 0; b < 4; b++) begin
            cyc(0, 0, 4'(1 << b), 0, 0, 0, 0);
            cyc(0, 0, 0, 0, 0, 1, 0);
            cyc(0, 0, 0, 0, 0, 0, 0);
        end
        // R2: disabled condition ignored, seen on sticky and on the pin after a frame start
        cyc(0, 0, 0, 1, 4'b1010, 0, 0);
        cyc(0, 1, 4'b0101, 0, 0, 0, 0);
        idle(3, 1);
        cyc(0, 0, 4'b0101, 0, 0, 0, 0);
        cyc(0, 1, 0, 0, 0, 0, 0);
        idle(3, 1);
        // R3: mask write in the same cycle as an error uses old enables
        tag_stk = "R3";
        cyc(0, 0, 4'b0001, 1, 4'b0001, 0, 0);
        idle(2, 0);
        cyc(0, 0, 4'b1000, 1, 4'b1111, 0, 0);
        cyc(0, 0, 0, 0, 0, 1, 0);
        idle(2, 0);
        // R7: read and error in the same cycle
        tag_stk = "R7";
        cyc(0, 0, 4'b0100, 0, 0, 0, 0);
        cyc(0, 0, 4'b0100, 0, 0, 1, 0);
        cyc(0, 0, 0, 0, 0, 1, 0);
        idle(2, 0);
        // R8: lone write pulse
        tag_irq = "R8";
        cyc(0, 0, 0, 0, 0, 0, 1);
        idle(12, 0);
        // R9: restart during delay and during pulse
        tag_irq = "R9";
        cyc(0, 0, 0, 0, 0, 0, 1);
        idle(3, 0);
        cyc(0, 0, 0, 0, 0, 0, 1);
        idle(6, 0);
        cyc(0, 0, 0, 0, 0, 0, 1);
        idle(12, 0);
        // R4/R5: frame-aligned pin, error on the frame-start cycle counts to the new frame
        tag_pin = "R4"; tag_irq = "R10";
        idle(2, 0);
        cyc(0, 1, 4'b0010, 0, 0, 0, 0);
        idle(5, 1); idle(4, 0);
        cyc(0, 1, 0, 0, 0, 1, 0);
        idle(5, 1); idle(4, 0);
        tag_pin = "R5";
        cyc(0, 1, 0, 0, 0, 0, 0);
        idle(4, 1);
        cyc(0, 0, 4'b1000, 0, 0, 0, 0);
        idle(3, 0);
        cyc(0, 1, 0, 0, 0, 1, 0);
        idle(9, 1);
        cyc(0, 0, 0, 0, 0, 0, 0);
        cyc(0, 1, 0, 0, 0, 0, 0);
        idle(3, 1);

        // random section with varying frame lengths
        tag_pin = "R5"; tag_stk = "R6"; tag_irq = "R10";
        for (int blk = 0; blk < 40; blk++) begin
            flen = (blk % 4 == 0) ? 64 : 6 + ($urandom % 20);
            phase = 0;
            for (int k = 0; k < 4 * flen; k++) begin
                logic [3:0] c;
                for (int b = 0; b < 4; b++) c[b] = (($urandom % 60) == 0);
                cyc(0, (phase < flen / 2), c, (($urandom % 150) == 0), 4'($urandom),
                    (($urandom % 25) == 0), (($urandom % 30) == 0));
                phase = (phase + 1) % flen;
            end
        end
        // R1: reset mid-run
        tag_pin = "R1"; tag_stk = "R1"; tag_irq = "R1";
        cyc(1, 1, 4'hF, 0, 0, 0, 1);
        cyc(0, 0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule